// File: doc/BRIEF.md
# Frame Sync Pulse Receiver with Automatic Polarity Correction

This block takes a 100 Hz frame sync pulse train that has already been turned into one logic level and brought into the local clock domain. Each nominal 10 ms period carries one positive pulse. Ordinary frames carry a short pulse. Every sixteenth frame (frame 0 of a multiframe) carries a pulse about three times as long. The block measures the high time of every pulse in units of a prescaled tick and sorts it into one of four classes: short, long, inverted or bad. From that sequence it recovers the frame number within the multiframe. It issues a frame strobe on the timing-critical falling edge, and a multiframe strobe when frame 0 arrives.

The waveform has very unequal high and low times. A swapped differential pair therefore shows up as a high time close to a whole period. When the block sees such a high time it flips its internal sense of the line and treats that same edge as the start of a true pulse. The lock flag rises once the sequence of long and short pulses has stayed regular for two full multiframes. The lock flag drops on any width or period fault, on a polarity flip, on a missing or early long pulse, and on loss of signal.

All time windows are parameters in ticks. With the default values (one tick = 125 clocks = 1 µs at 125 MHz) the windows are:
- short: 5 µs to 1 ms
- long: 2 ms to 5 ms
- inverted: just above 5 ms up to one period
- period: 10 ms ±1%
- loss of signal: 20 ms

Top module: `dsync_rx`

## Requirements
- R1: A pulse whose measured high time lies in [NORM_MIN, NORM_MAX] ticks raises `frame_stb` for one cycle just after its falling edge, with `mf_stb` low, and advances `frame_num` by one modulo MF_LEN.
- R2: A pulse whose measured high time lies in [LONG_MIN, LONG_MAX] ticks raises `frame_stb` and `mf_stb` together for one cycle just after its falling edge, with `frame_num` equal to 0.
- R3: A high time below NORM_MIN, between NORM_MAX and LONG_MIN, or above INV_MAX raises `err_stb` for one cycle without `frame_stb`, leaves `frame_num` unchanged, and clears `locked`.
- R4: A high time in [INV_MIN, INV_MAX] toggles `pol_inv`, gives no strobe, and clears `locked`. From that edge on, the line is read inverted: a falling line edge starts a pulse and a rising line edge ends it.
- R5: When two consecutive pulse starts lie less than PER_MIN or more than PER_MAX ticks apart, `err_stb` pulses for one cycle at the second start and `locked` clears. No period is checked across a polarity flip without a previous start, or across loss of signal.
- R6: `locked` rises, together with `mf_stb`, on the long pulse that closes the second consecutive multiframe of exactly MF_LEN-1 short pulses followed by one long pulse.
- R7: A short pulse arriving where a long pulse is due (MF_LEN short pulses in a row after a long pulse), or a long pulse arriving early, clears `locked`.
- R8: If no pulse start is seen for LOS_TICKS ticks, `los` goes high and `locked` is low from the next cycle. `los` returns low at the next pulse start.
- R9: After reset, `frame_num` is 0 and `frame_stb`, `mf_stb`, `err_stb`, `pol_inv`, `locked` and `los` are all 0.
- R10: `mf_stb` is never high without `frame_stb` and `frame_num` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Sync line, already single-ended and synchronized |
| frame_num | output | $clog2(MF_LEN) | Recovered frame number within the multiframe |
| frame_stb | output | 1 | One-cycle strobe after each valid pulse's falling edge |
| mf_stb | output | 1 | One-cycle strobe for the frame-0 (long) pulse |
| pol_inv | output | 1 | The line is being read inverted |
| locked | output | 1 | The multiframe pattern has been regular for two multiframes |
| err_stb | output | 1 | One-cycle strobe on a width or period fault |
| los | output | 1 | No pulse start within the loss-of-signal time |

## Verification
The hardest situation to reach is the polarity handover. One line edge must end an impossible high time and, in the same cycle, start a real pulse. After that, strobes must follow the rising line edges. To get there, the bench resets the receiver and drives a full stream with the line idling high between pulses. The first visible high time is then nearly a whole period. The bench checks that this edge yields no strobe, that the following long pulse is still frame 0, that no period fault is raised for it, and that lock is reached two multiframes later with `pol_inv` set. Lock loss through a withheld long pulse is reached by running a locked stream and then sending a sixteenth short pulse in a row.

// File: rtl/dsync_pkg.sv
// Shared types for the frame sync receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package dsync_pkg;

    // Class given to one measured pulse at its end edge.
    typedef enum logic [2:0] {
        PK_NONE  = 3'd0,   // no pulse ended this cycle
        PK_SHORT = 3'd1,   // ordinary frame pulse
        PK_LONG  = 3'd2,   // frame-0 pulse
        PK_FLIP  = 3'd3,   // high time only explainable by a swapped pair
        PK_BAD   = 3'd4    // width outside every window
    } pulse_kind_e;

endpackage

// File: rtl/dsync_tick.sv
// Tick prescaler: raises tick once every CLK_PER_TICK clocks.
// Assumes: CLK_PER_TICK >= 1; a value of 1 gives a tick on every clock.
module dsync_tick #(
    parameter int CLK_PER_TICK = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [TW-1:0] LAST = TW'(CLK_PER_TICK - 1);

    logic [TW-1:0] div_q;

    // Free-running divider, wraps at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

endmodule

// File: rtl/dsync_meas.sv
// Edge and width measurement with polarity correction.
// Samples the line twice to find edges. A polarity register decides which
// line edge starts a pulse and which ends it. One since-start counter, in
// ticks, gives both the high time (at the end edge) and the period (at the
// next start). A high time in the inverted window flips the polarity and
// restarts the counter on that same edge, since the edge is then a real
// pulse start.
// Assumes: LOS_TICKS is the largest time parameter; the input is already
// synchronized to clk.
module dsync_meas import dsync_pkg::*; #(
    parameter int NORM_MIN  = 5,
    parameter int NORM_MAX  = 1000,
    parameter int LONG_MIN  = 2000,
    parameter int LONG_MAX  = 5000,
    parameter int INV_MIN   = 5001,
    parameter int INV_MAX   = 9999,
    parameter int PER_MIN   = 9900,
    parameter int PER_MAX   = 10100,
    parameter int LOS_TICKS = 20000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        sync_in,
    output pulse_kind_e kind,
    output logic        per_err,
    output logic        pol_inv,
    output logic        los
);
    localparam int CW = $clog2(LOS_TICKS + 1);
    localparam logic [CW-1:0] NMIN_C = CW'(NORM_MIN);
    localparam logic [CW-1:0] NMAX_C = CW'(NORM_MAX);
    localparam logic [CW-1:0] LMIN_C = CW'(LONG_MIN);
    localparam logic [CW-1:0] LMAX_C = CW'(LONG_MAX);
    localparam logic [CW-1:0] IMIN_C = CW'(INV_MIN);
    localparam logic [CW-1:0] IMAX_C = CW'(INV_MAX);
    localparam logic [CW-1:0] PMIN_C = CW'(PER_MIN);
    localparam logic [CW-1:0] PMAX_C = CW'(PER_MAX);
    localparam logic [CW-1:0] LOS_C  = CW'(LOS_TICKS);

    logic          d_q, d_q2;
    logic          pol_q, have_prev_q, los_q;
    logic [CW-1:0] cnt_q;
    logic          raw_rise, raw_fall, t_rise, t_fall, restart;

    // Two-stage history of the line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q  <= 1'b0;
            d_q2 <= 1'b0;
        end else begin
            d_q  <= sync_in;
            d_q2 <= d_q;
        end
    end

    // Map raw line edges to pulse start and end through the polarity.
    always_comb begin
        raw_rise = d_q & ~d_q2;
        raw_fall = ~d_q & d_q2;
        t_rise   = pol_q ? raw_fall : raw_rise;
        t_fall   = pol_q ? raw_rise : raw_fall;
    end

    // Sort the high time into a class at the pulse end edge.
    always_comb begin
        kind = PK_NONE;
        if (t_fall) begin
            if (cnt_q >= NMIN_C && cnt_q <= NMAX_C)
                kind = PK_SHORT;
            else if (cnt_q >= LMIN_C && cnt_q <= LMAX_C)
                kind = PK_LONG;
            else if (cnt_q >= IMIN_C && cnt_q <= IMAX_C)
                kind = PK_FLIP;
            else
                kind = PK_BAD;
        end
    end

    assign per_err = t_rise && have_prev_q && (cnt_q < PMIN_C || cnt_q > PMAX_C);
    assign restart = t_rise || (kind == PK_FLIP);

    // Ticks since the last pulse start, saturating at the loss limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= {{(CW-1){1'b0}}, 1'b1};
        else if (tick && cnt_q < LOS_C)
            cnt_q <= cnt_q + 1'b1;
    end

    // Previous-start validity and loss of signal, both tied to the counter limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
            los_q       <= 1'b0;
        end else if (restart) begin
            have_prev_q <= 1'b1;
            los_q       <= 1'b0;
        end else if (cnt_q == LOS_C) begin
            have_prev_q <= 1'b0;
            los_q       <= 1'b1;
        end
    end

    // Polarity register, flipped by an inverted-window high time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_q <= 1'b0;
        else if (kind == PK_FLIP)
            pol_q <= ~pol_q;
    end

    assign pol_inv = pol_q;
    assign los     = los_q;

    // R8: a pulse start always ends loss of signal.
    p_los_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (los_q && t_rise) |=> !los_q);

    // R4: an inverted-window high time changes how the next edge is read.
    p_flip_swaps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PK_FLIP) |=> (pol_q != $past(pol_q)));

endmodule

// File: rtl/dsync_track.sv
// Frame counter, strobes and lock state.
// Consumes one classified event per pulse. It counts frames modulo MF_LEN,
// forces frame 0 on a long pulse, counts short pulses since the last long
// one, and counts consecutive regular multiframes up to LOCK_MF. Any fault,
// polarity flip or loss of signal drops lock and restarts the count.
// Assumes: at most one event per cycle; MF_LEN >= 2; LOCK_MF >= 1.
module dsync_track import dsync_pkg::*; #(
    parameter int MF_LEN  = 16,
    parameter int LOCK_MF = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  pulse_kind_e               kind,
    input  logic                      per_err,
    input  logic                      los,
    output logic [$clog2(MF_LEN)-1:0] frame_num,
    output logic                      frame_stb,
    output logic                      mf_stb,
    output logic                      err_stb,
    output logic                      locked
);
    localparam int FW = $clog2(MF_LEN);
    localparam int GW = $clog2(LOCK_MF + 1);
    localparam logic [FW-1:0] LAST_F = FW'(MF_LEN - 1);
    localparam logic [GW-1:0] GOAL   = GW'(LOCK_MF);

    logic [FW-1:0] frame_q, pcnt_q;
    logic [GW-1:0] good_q;
    logic          seen_q, lock_q, fstb_q, mstb_q, estb_q;
    logic          drop;

    assign drop = (kind == PK_BAD) || (kind == PK_FLIP) || per_err || los;

    // Frame number and the two frame strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            fstb_q  <= 1'b0;
            mstb_q  <= 1'b0;
            estb_q  <= 1'b0;
        end else begin
            fstb_q <= (kind == PK_SHORT) || (kind == PK_LONG);
            mstb_q <= (kind == PK_LONG);
            estb_q <= (kind == PK_BAD) || per_err;
            if (kind == PK_LONG)
                frame_q <= '0;
            else if (kind == PK_SHORT)
                frame_q <= (frame_q == LAST_F) ? '0 : frame_q + 1'b1;
        end
    end

    // Regular-multiframe counting and the lock decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            good_q <= '0;
            seen_q <= 1'b0;
            lock_q <= 1'b0;
        end else if (drop) begin
            pcnt_q <= '0;
            good_q <= '0;
            seen_q <= 1'b0;
            lock_q <= 1'b0;
        end else if (kind == PK_LONG) begin
            pcnt_q <= '0;
            seen_q <= 1'b1;
            if (seen_q && pcnt_q == LAST_F) begin
                good_q <= (good_q == GOAL) ? GOAL : good_q + 1'b1;
                if (good_q >= GOAL - 1'b1)
                    lock_q <= 1'b1;
            end else if (seen_q) begin
                good_q <= '0;
                lock_q <= 1'b0;
            end
        end else if (kind == PK_SHORT) begin
            if (seen_q && pcnt_q == LAST_F) begin
                pcnt_q <= '0;
                good_q <= '0;
                seen_q <= 1'b0;
                lock_q <= 1'b0;
            end else if (pcnt_q != LAST_F) begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    assign frame_num = frame_q;
    assign frame_stb = fstb_q;
    assign mf_stb    = mstb_q;
    assign err_stb   = estb_q;
    assign locked    = lock_q;

    // R10: multiframe strobe only with a frame strobe at frame 0.
    p_mf_frame0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mf_stb |-> (frame_stb && frame_num == '0));

    // R1: an ordinary strobe steps the frame number by one.
    p_frame_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !mf_stb) |->
            (frame_num == (($past(frame_num) == LAST_F) ? '0 : $past(frame_num) + 1'b1)));

    // R3: a fault strobe never coincides with lock or a frame strobe.
    p_err_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_stb |-> (!locked && !frame_stb));

    // R6: lock is only gained on a frame-0 pulse.
    p_lock_on_mf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> mf_stb);

endmodule

// File: rtl/dsync_rx.sv
// Top level of the frame sync receiver: prescaler, measurement, tracker.
// Assumes: sync_in is synchronized to clk; all windows are in ticks of
// CLK_PER_TICK clocks, with LOS_TICKS the largest of them.
module dsync_rx import dsync_pkg::*; #(
    parameter int CLK_PER_TICK = 125,
    parameter int NORM_MIN     = 5,
    parameter int NORM_MAX     = 1000,
    parameter int LONG_MIN     = 2000,
    parameter int LONG_MAX     = 5000,
    parameter int INV_MIN      = 5001,
    parameter int INV_MAX      = 9999,
    parameter int PER_MIN      = 9900,
    parameter int PER_MAX      = 10100,
    parameter int LOS_TICKS    = 20000,
    parameter int MF_LEN       = 16,
    parameter int LOCK_MF      = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sync_in,
    output logic [$clog2(MF_LEN)-1:0] frame_num,
    output logic                      frame_stb,
    output logic                      mf_stb,
    output logic                      pol_inv,
    output logic                      locked,
    output logic                      err_stb,
    output logic                      los
);
    logic        tick;
    pulse_kind_e kind;
    logic        per_err;

    dsync_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dsync_meas #(
        .NORM_MIN  (NORM_MIN),
        .NORM_MAX  (NORM_MAX),
        .LONG_MIN  (LONG_MIN),
        .LONG_MAX  (LONG_MAX),
        .INV_MIN   (INV_MIN),
        .INV_MAX   (INV_MAX),
        .PER_MIN   (PER_MIN),
        .PER_MAX   (PER_MAX),
        .LOS_TICKS (LOS_TICKS)
    ) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sync_in (sync_in),
        .kind    (kind),
        .per_err (per_err),
        .pol_inv (pol_inv),
        .los     (los)
    );

    dsync_track #(
        .MF_LEN  (MF_LEN),
        .LOCK_MF (LOCK_MF)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .per_err   (per_err),
        .los       (los),
        .frame_num (frame_num),
        .frame_stb (frame_stb),
        .mf_stb    (mf_stb),
        .err_stb   (err_stb),
        .locked    (locked)
    );

    // R4: a polarity change lands with lock already dropped.
    p_pol_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_inv) |-> !locked);

    // R8: loss of signal removes lock by the next cycle.
    p_los_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        los |=> !locked);

endmodule

// File: tb/dsync_rx_test.sv
`timescale 1ns/1ps
module dsync_rx_test;
    // Scaled windows: 1 tick per clock, period 100 ticks.
    localparam int P_NOM = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line = 1'b0;
    logic [3:0] frame_num;
    logic       frame_stb, mf_stb, pol_inv, locked, err_stb, los;

    always #4 clk = ~clk;

    dsync_rx #(
        .CLK_PER_TICK(1), .NORM_MIN(1), .NORM_MAX(10), .LONG_MIN(20), .LONG_MAX(50),
        .INV_MIN(51), .INV_MAX(99), .PER_MIN(99), .PER_MAX(101), .LOS_TICKS(200),
        .MF_LEN(16), .LOCK_MF(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sync_in(line), .frame_num(frame_num),
        .frame_stb(frame_stb), .mf_stb(mf_stb), .pol_inv(pol_inv),
        .locked(locked), .err_stb(err_stb), .los(los)
    );

    typedef struct {
        bit    is_err;
        int    frame;
        bit    mf;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   fexp = 0;
    bit   have_prev = 0;
    int   prev_per = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(input bit is_err, input bit mf, input string req);
        exp_t e;
        e.is_err = is_err;
        e.mf     = mf;
        e.frame  = fexp;
        e.req    = req;
        q.push_back(e);
    endtask

    // Driver: one pulse of hi true-high cycles in a period of per cycles.
    task automatic pulse(input int hi, input int per, input bit inv, input bit track);
        if (track) begin
            if (have_prev && (prev_per < 99 || prev_per > 101))
                push(1'b1, 1'b0, "R5");
            if (hi >= 1 && hi <= 10) begin
                fexp = (fexp + 1) % 16;
                push(1'b0, 1'b0, "R1");
            end else if (hi >= 20 && hi <= 50) begin
                fexp = 0;
                push(1'b0, 1'b1, "R2");
            end else begin
                push(1'b1, 1'b0, "R3");
            end
        end
        have_prev = track;
        prev_per  = per;
        line = inv ? 1'b0 : 1'b1;
        repeat (hi) @(negedge clk);
        line = inv ? 1'b1 : 1'b0;
        repeat (per - hi) @(negedge clk);
    endtask

    // A stream with a long pulse where (i + phase) % 16 == 0.
    task automatic stream(input int n, input int phase, input bit inv);
        for (int i = 0; i < n; i++) begin
            bit lng;
            lng = (((i + phase) % 16) == 0);
            pulse(lng ? 26 : 9, P_NOM, inv, !(inv && i == 0));
        end
    endtask

    task automatic idle(input int n, input bit lvl);
        line = lvl;
        repeat (n) @(negedge clk);
        have_prev = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        line  = 1'b0;
        repeat (5) @(negedge clk);
        q.delete();
        fexp = 0;
        have_prev = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: pop one expectation per strobe and compare.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (frame_stb || err_stb)) begin
            if (q.size() == 0) begin
                check(1'b0, "R1", "unexpected strobe (frame_stb)", int'(frame_stb), 0);
            end else begin
                e = q.pop_front();
                if (e.is_err) begin
                    check(err_stb && !frame_stb, e.req, "fault strobe", int'(err_stb), 1);
                end else begin
                    check(frame_stb && !err_stb, e.req, "frame strobe", int'(frame_stb), 1);
                    check(int'(frame_num) == e.frame, e.req, "frame_num", int'(frame_num), e.frame);
                    check(mf_stb == e.mf, e.req, "mf_stb", int'(mf_stb), int'(e.mf));
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R9: reset state
        check(frame_num == 0, "R9", "frame_num", int'(frame_num), 0);
        check(!frame_stb && !mf_stb && !err_stb, "R9", "strobes", int'(frame_stb | mf_stb | err_stb), 0);
        check(!pol_inv, "R9", "pol_inv", int'(pol_inv), 0);
        check(!locked, "R9", "locked", int'(locked), 0);
        check(!los, "R9", "los", int'(los), 0);

        // R6: one multiframe is not enough, two are
        stream(17, 0, 1'b0);
        check(!locked, "R6", "locked after one multiframe", int'(locked), 0);
        stream(16, 1, 1'b0);
        check(locked, "R6", "locked after two multiframes", int'(locked), 1);

        // R7: missing long pulse
        for (int i = 0; i < 15; i++) pulse(9, P_NOM, 1'b0, 1'b1);
        check(locked, "R7", "locked before due long", int'(locked), 1);
        pulse(9, P_NOM, 1'b0, 1'b1);
        check(!locked, "R7", "locked after missing long", int'(locked), 0);

        // R7: early long pulse
        stream(33, 0, 1'b0);
        check(locked, "R6", "relock", int'(locked), 1);
        for (int i = 0; i < 10; i++) pulse(9, P_NOM, 1'b0, 1'b1);
        pulse(26, P_NOM, 1'b0, 1'b1);
        check(!locked, "R7", "locked after early long", int'(locked), 0);

        // R1 R2 R3: width window edges
        stream(33, 0, 1'b0);
        pulse(10, P_NOM, 1'b0, 1'b1);
        pulse(1, P_NOM, 1'b0, 1'b1);
        pulse(20, P_NOM, 1'b0, 1'b1);
        pulse(50, P_NOM, 1'b0, 1'b1);
        check(!locked, "R7", "locked after irregular longs", int'(locked), 0);
        stream(33, 0, 1'b0);
        pulse(11, P_NOM, 1'b0, 1'b1);
        check(!locked, "R3", "locked after width 11", int'(locked), 0);
        pulse(19, P_NOM, 1'b0, 1'b1);
        pulse(15, P_NOM, 1'b0, 1'b1);
        pulse(9, P_NOM, 1'b0, 1'b1);

        // R5: period window edges
        stream(33, 0, 1'b0);
        pulse(9, 102, 1'b0, 1'b1);
        pulse(9, 101, 1'b0, 1'b1);
        check(!locked, "R5", "locked after period 102", int'(locked), 0);
        pulse(9, 99, 1'b0, 1'b1);
        pulse(9, 98, 1'b0, 1'b1);
        pulse(9, P_NOM, 1'b0, 1'b1);
        pulse(9, P_NOM, 1'b0, 1'b1);

        // R8: loss of signal
        stream(33, 0, 1'b0);
        check(locked, "R8", "locked before gap", int'(locked), 1);
        idle(250, 1'b0);
        check(los, "R8", "los after gap", int'(los), 1);
        check(!locked, "R8", "locked after gap", int'(locked), 0);
        pulse(9, P_NOM, 1'b0, 1'b1);
        check(!los, "R8", "los after new pulse", int'(los), 0);

        // R4: swapped pair, line idles high between pulses
        do_reset();
        stream(40, 15, 1'b1);
        check(pol_inv, "R4", "pol_inv", int'(pol_inv), 1);
        check(locked, "R4", "locked with inverted line", int'(locked), 1);

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R1", "pending expected strobes", q.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule